// File: doc/BRIEF.md
# AMI Line Encoder and Receive Front End

This block sits between a 1.544 Mbit/s serial framer and a bipolar T1 line interface. On the transmit side it takes one unipolar NRZ bit per transmit clock. It turns that bit into two unipolar drive rails: one rail pulses for positive marks and the other for negative marks. A bipolar driver outside the block combines the two rails into an alternate-mark-inversion signal. Each mark takes the opposite polarity to the mark before it. Spaces leave both rails idle.

On the receive side the line signal arrives already split into two active-low unipolar rails. It also arrives as a combined data input, which is the NAND of the two rails. All three inputs are captured on the falling edge of the recovered line clock. The block puts out NRZ receive data and a one-cycle bipolar-violation flag that lines up with the offending bit. When both rails are tied high and NRZ data is fed straight into the combined input, violation checking is suppressed.

Top module: `ami_line_port`

## Requirements
- R1: A transmit bit of 1 is a mark. Marks alternate between the positive rail and the negative rail, and the first mark after reset goes out on the positive rail. A rail output reflects the bit presented at the previous rising transmit clock edge.
- R2: A transmit bit of 0 drives both transmit rails low, and the two transmit rails are never high together.
- R3: The receive inputs are captured on the falling edge of the receive clock. The NRZ receive output equals the combined input captured one falling edge earlier, so each bit appears after two falling edges.
- R4: A mark on the same receive rail as the previous mark raises the violation flag for exactly the output cycle that carries that bit, however many spaces lie between the two marks.
- R5: A bit with both receive rails low flags a violation and leaves the record of the last mark polarity unchanged.
- R6: A bit with both receive rails high and the combined input at 1 is direct NRZ data. It never flags a violation, and it clears the last-mark record, so the next mark is never flagged.
- R7: While reset is held, the transmit rails, the receive data and the violation flag are all 0. After reset, transmit polarity starts positive and the receive last-mark record starts empty.
- R8: The receive rails are active low: a rail level of 0 means a mark of that polarity, and a level of 1 means no mark on that rail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx | input | 1 | Transmit bit clock, rising edge |
| clk_rx | input | 1 | Recovered receive clock, falling edge |
| rst_n | input | 1 | Synchronous active-low reset, seen by both clock domains |
| tx_nrz | input | 1 | Unipolar transmit bit |
| tx_rail_pos | output | 1 | Positive-mark drive rail, active high |
| tx_rail_neg | output | 1 | Negative-mark drive rail, active high |
| rx_rail_pos_n | input | 1 | Positive-mark receive rail, active low |
| rx_rail_neg_n | input | 1 | Negative-mark receive rail, active low |
| rx_comb | input | 1 | Combined receive data (NAND of the rails, or direct NRZ) |
| rx_nrz | output | 1 | Recovered NRZ receive data |
| rx_bpv | output | 1 | Bipolar-violation pulse, aligned with rx_nrz |

## Verification
The violation pulse and the data bit it belongs to must come out in the same output cycle. A flag that lags or leads its bit by one cycle is a distinct failure. The vector table places repeated same-rail marks, both-rails-low bits and direct-NRZ bits next to one another. Each output sample is then judged on rx_nrz and rx_bpv together against the row that produced them. Transmit encoding runs in the same cycles. Every row also checks the rail that alternation should pick.

// File: rtl/ami_pkg.sv
// Package: shared types for the AMI line port.
// Assumes: a single-bit line on each rail; polarity and history are small enums.
package ami_pkg;

    // Polarity that the next transmitted mark will take.
    typedef enum logic {
        POL_POS = 1'b0,
        POL_NEG = 1'b1
    } tx_pol_e;

    // Rail of the most recent received mark, or none.
    typedef enum logic [1:0] {
        HIST_NONE = 2'd0,
        HIST_POS  = 2'd1,
        HIST_NEG  = 2'd2
    } mark_hist_e;

    // One captured receive bit, rails converted to active-high marks.
    typedef struct packed {
        logic mark_pos;
        logic mark_neg;
        logic comb;
    } rx_sample_t;

endpackage

// File: rtl/ami_tx_encoder.sv
// Module: ami_tx_encoder
// Turns one unipolar bit per clock into two active-high AMI drive rails.
// Assumes: one bit per rising clk edge; synchronous active-low reset.
module ami_tx_encoder
    import ami_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic rail_pos,
    output logic rail_neg
);

    tx_pol_e pol_q;

    // Register the rails and flip polarity after every mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q    <= POL_POS;
            rail_pos <= 1'b0;
            rail_neg <= 1'b0;
        end else if (bit_in) begin
            rail_pos <= (pol_q == POL_POS);
            rail_neg <= (pol_q == POL_NEG);
            pol_q    <= (pol_q == POL_POS) ? POL_NEG : POL_POS;
        end else begin
            rail_pos <= 1'b0;
            rail_neg <= 1'b0;
        end
    end

    // R2: the drive rails never assert together.
    p_rails_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rail_pos && rail_neg));

    // R2: a space leaves both rails idle on the next cycle.
    p_space_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_in |=> !(rail_pos || rail_neg));

    // R1: a mark with positive polarity pending comes out on the positive rail.
    p_mark_pos_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_in && pol_q == POL_POS) |=> rail_pos);

    // R1: two marks in a row use opposite rails.
    p_alternate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_in && rail_pos) |=> rail_neg);

endmodule

// File: rtl/ami_rx_sampler.sv
// Module: ami_rx_sampler
// Captures the receive rails and combined input on the falling line-clock edge.
// Assumes: rails are active low; comb is their NAND or direct NRZ data.
module ami_rx_sampler
    import ami_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rail_pos_n,
    input  logic       rail_neg_n,
    input  logic       comb,
    output rx_sample_t smp
);

    // Capture inputs on the falling edge and convert rails to active-high marks.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            smp <= '0;
        end else begin
            smp.mark_pos <= ~rail_pos_n;
            smp.mark_neg <= ~rail_neg_n;
            smp.comb     <= comb;
        end
    end

    // R8: a low positive rail is recorded as a positive mark.
    p_active_low_r8: assert property (@(negedge clk) disable iff (!rst_n)
        !rail_pos_n |=> smp.mark_pos);

endmodule

// File: rtl/ami_rx_decoder.sv
// Module: ami_rx_decoder
// Recovers NRZ data and flags bipolar violations from captured samples.
// Assumes: one sample per falling clk edge; synchronous active-low reset.
module ami_rx_decoder
    import ami_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rx_sample_t smp,
    output logic       nrz,
    output logic       bpv
);

    mark_hist_e hist_q;
    mark_hist_e hist_d;
    logic       bpv_d;
    logic       direct_nrz;

    // A bit with no rail mark but a set combined input is direct NRZ data.
    assign direct_nrz = !smp.mark_pos && !smp.mark_neg && smp.comb;

    // Classify the sample: violation decision and next last-mark record.
    always_comb begin
        hist_d = hist_q;
        bpv_d  = 1'b0;
        if (smp.mark_pos && smp.mark_neg) begin
            bpv_d = 1'b1;
        end else if (smp.mark_pos) begin
            bpv_d  = (hist_q == HIST_POS);
            hist_d = HIST_POS;
        end else if (smp.mark_neg) begin
            bpv_d  = (hist_q == HIST_NEG);
            hist_d = HIST_NEG;
        end else if (direct_nrz) begin
            hist_d = HIST_NONE;
        end
    end

    // Register data, flag and history together so the flag aligns with its bit.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            hist_q <= HIST_NONE;
            nrz    <= 1'b0;
            bpv    <= 1'b0;
        end else begin
            hist_q <= hist_d;
            nrz    <= smp.comb;
            bpv    <= bpv_d;
        end
    end

    // R6: a direct-NRZ bit never raises the flag.
    p_bypass_quiet_r6: assert property (@(negedge clk) disable iff (!rst_n)
        direct_nrz |=> !bpv);

    // R5: both rails marked always flags.
    p_double_mark_r5: assert property (@(negedge clk) disable iff (!rst_n)
        (smp.mark_pos && smp.mark_neg) |=> bpv);

    // R5: both rails marked keeps the last-mark record.
    p_double_keeps_hist_r5: assert property (@(negedge clk) disable iff (!rst_n)
        (smp.mark_pos && smp.mark_neg) |=> $stable(hist_q));

    // R3: the output data follows the captured combined input.
    p_data_follows_r3: assert property (@(negedge clk) disable iff (!rst_n)
        smp.comb |=> nrz);

    // R4: a positive mark after a positive mark flags.
    p_repeat_pos_r4: assert property (@(negedge clk) disable iff (!rst_n)
        (smp.mark_pos && !smp.mark_neg && hist_q == HIST_POS) |=> bpv);

endmodule

// File: rtl/ami_line_port.sv
// Module: ami_line_port
// Top of the AMI line encoder and receive front end.
// Assumes: clk_tx and clk_rx may be unrelated; rst_n is synchronous to each.
module ami_line_port
    import ami_pkg::*;
(
    input  logic clk_tx,
    input  logic clk_rx,
    input  logic rst_n,
    input  logic tx_nrz,
    output logic tx_rail_pos,
    output logic tx_rail_neg,
    input  logic rx_rail_pos_n,
    input  logic rx_rail_neg_n,
    input  logic rx_comb,
    output logic rx_nrz,
    output logic rx_bpv
);

    rx_sample_t rx_smp;

    // Transmit path: unipolar bit to alternating rails.
    ami_tx_encoder u_tx (
        .clk      (clk_tx),
        .rst_n    (rst_n),
        .bit_in   (tx_nrz),
        .rail_pos (tx_rail_pos),
        .rail_neg (tx_rail_neg)
    );

    // Receive capture stage.
    ami_rx_sampler u_smp (
        .clk        (clk_rx),
        .rst_n      (rst_n),
        .rail_pos_n (rx_rail_pos_n),
        .rail_neg_n (rx_rail_neg_n),
        .comb       (rx_comb),
        .smp        (rx_smp)
    );

    // Receive decode stage.
    ami_rx_decoder u_dec (
        .clk   (clk_rx),
        .rst_n (rst_n),
        .smp   (rx_smp),
        .nrz   (rx_nrz),
        .bpv   (rx_bpv)
    );

    // R4: a violation is only flagged on a bit that carries data.
    p_bpv_on_data_r4: assert property (@(negedge clk_rx) disable iff (!rst_n)
        rx_bpv |-> rx_nrz);

endmodule

// File: tb/sim_ami_line_port.sv
module sim_ami_line_port;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_nrz = 1'b0;
    logic rx_rail_pos_n = 1'b1;
    logic rx_rail_neg_n = 1'b1;
    logic rx_comb = 1'b0;
    logic tx_rail_pos, tx_rail_neg, rx_nrz, rx_bpv;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ami_line_port u0 (
        .clk_tx        (clk),
        .clk_rx        (clk),
        .rst_n         (rst_n),
        .tx_nrz        (tx_nrz),
        .tx_rail_pos   (tx_rail_pos),
        .tx_rail_neg   (tx_rail_neg),
        .rx_rail_pos_n (rx_rail_pos_n),
        .rx_rail_neg_n (rx_rail_neg_n),
        .rx_comb       (rx_comb),
        .rx_nrz        (rx_nrz),
        .rx_bpv        (rx_bpv)
    );

    // Row fields: [7] tx bit, [6] rx pos rail (active low), [5] rx neg rail,
    // [4] combined input, [3] exp tx pos, [2] exp tx neg, [1] exp data, [0] exp bpv
    localparam int NV = 16;
    localparam logic [7:0] VEC [NV] = '{
        8'b1011_1010,  // first mark positive; rx pos mark
        8'b0110_0000,  // space
        8'b1101_0110,  // neg mark
        8'b1011_1010,  // pos mark
        8'b1011_0111,  // R4 repeat pos mark flags
        8'b0110_0000,  // space
        8'b0101_0010,  // neg mark
        8'b1110_1000,  // space on rx
        8'b1101_0111,  // R4 neg after neg across a space
        8'b1001_1011,  // R5 both rails low
        8'b0011_0010,  // pos mark, record was still neg
        8'b1111_0110,  // R6 direct NRZ one
        8'b0110_0000,  // direct NRZ zero
        8'b1011_1010,  // pos mark after cleared record: no flag
        8'b1111_0110,  // R6 direct NRZ one clears again
        8'b1101_1010   // neg mark after cleared record: no flag
    };

    task automatic chk(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic t, input logic pn, input logic nn, input logic c);
        tx_nrz = t;
        rx_rail_pos_n = pn;
        rx_rail_neg_n = nn;
        rx_comb = c;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        drive(1'b0, 1'b1, 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        #1;
        // R7: outputs idle during reset
        chk(tx_rail_pos, 1'b0, "R7 reset tx_pos");
        chk(tx_rail_neg, 1'b0, "R7 reset tx_neg");
        chk(rx_nrz, 1'b0, "R7 reset rx_nrz");
        chk(rx_bpv, 1'b0, "R7 reset rx_bpv");
        rst_n = 1'b1;

        // Vector walk: tx output one edge later, rx output two edges later
        for (int j = 0; j < NV + 2; j++) begin
            @(posedge clk);
            #1;
            if (j >= 1 && j <= NV) begin
                chk(tx_rail_pos, VEC[j-1][3], $sformatf("R1 R2 row%0d tx_pos", j-1));
                chk(tx_rail_neg, VEC[j-1][2], $sformatf("R1 R2 row%0d tx_neg", j-1));
            end
            if (j >= 2) begin
                chk(rx_nrz, VEC[j-2][1], $sformatf("R3 R8 row%0d rx_nrz", j-2));
                chk(rx_bpv, VEC[j-2][0], $sformatf("R4 R5 R6 row%0d rx_bpv", j-2));
            end
            if (j < NV)
                drive(VEC[j][7], VEC[j][6], VEC[j][5], VEC[j][4]);
            else
                drive(1'b0, 1'b1, 1'b1, 1'b0);
        end

        // Directed: reset clears polarity and history (R7).
        // Tx polarity is now negative; rx record is negative.
        drive(1'b0, 1'b1, 1'b0, 1'b1);
        repeat (3) begin
            @(posedge clk);
            #1;
            drive(1'b0, 1'b1, 1'b1, 1'b0);
        end
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(rx_bpv, 1'b0, "R7 mid-run reset rx_bpv");
        chk(tx_rail_pos, 1'b0, "R7 mid-run reset tx_pos");
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        drive(1'b1, 1'b1, 1'b0, 1'b1);
        @(posedge clk);
        #1;
        chk(tx_rail_pos, 1'b1, "R7 R1 first mark after reset positive");
        chk(tx_rail_neg, 1'b0, "R7 R1 first mark after reset not negative");
        drive(1'b0, 1'b1, 1'b1, 1'b0);
        @(posedge clk);
        #1;
        chk(rx_nrz, 1'b1, "R7 R3 first rx mark after reset data");
        chk(rx_bpv, 1'b0, "R7 R4 first rx mark after reset not flagged");

        // Directed: a long stretch of direct NRZ ones never flags (R6).
        drive(1'b0, 1'b1, 1'b1, 1'b1);
        repeat (2) @(posedge clk);
        for (int k = 0; k < 6; k++) begin
            @(posedge clk);
            #1;
            chk(rx_nrz, 1'b1, "R6 bypass run data");
            chk(rx_bpv, 1'b0, "R6 bypass run no flag");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule